// File: doc/BRIEF.md
# Length-Detecting Three-Wire Tuning Word Loader

This block receives tuning words over a three-wire serial link made of an enable line, a serial clock and a serial data line. While enable is high, one data bit is taken on every falling edge of the serial clock. The number of bits seen before enable drops tells the block which of three word formats was sent: 18 bits, 19 bits or 27 bits. Each format fills the tuning registers differently, and each gives the reference-ratio bit a different value.

Every word starts with four band-select bits. These bits take effect while the word is still arriving. A frequency divider field of 14 or 15 bits comes next. The long format adds a trailing control byte that sets the pump current, the test mode, both ratio bits and the tuning-output disable. The short formats leave every control field untouched except the one ratio bit that the word length implies.

The three serial lines are sampled on the system clock, and their edges are detected there, so the serial clock must run well below the system clock. A synchronous reset stands in for power-on and loads the documented start-up values.

Top module: `serial_tune_loader`

## Requirements
- R1: After reset: band_o=0, freq_o=0, cp_o=1, os_o=1, test_o=3'b001, rsa_o=0.
- R2: A bit is captured only on a falling serial-clock edge while sen_i is high. Serial-clock activity while sen_i is low changes no output.
- R3: The first four bits of a word go to band_o, first bit into band_o[3], on the 5th rising serial-clock edge of the word. Words shorter than 18 bits also do this.
- R4: When enable falls after exactly 18 bits, freq_o becomes {0, last 14 bits} and rsa_o becomes 1.
- R5: When enable falls after exactly 19 bits, freq_o becomes the last 15 bits, MSB first, and rsa_o becomes 0.
- R6: On the 20th rising serial-clock edge, freq_o takes bits 5..19 of the word, MSB first. When enable falls after exactly 27 bits, the last 8 bits are decoded as [ignored, cp, t2, t1, t0, rsa, rsb, os] in arrival order, and freq_o keeps the value loaded at the 20th edge.
- R7: cp_o, test_o, rsb_o and os_o keep their values across 18-bit and 19-bit words.
- R8: A word shorter than 18 bits leaves freq_o and rsa_o unchanged.
- R9: A word of any other length of 20 bits or more changes no control output and leaves rsa_o unchanged. Only the band load and the 20th-edge frequency load take effect.
- R10: The reset value of rsb_o equals parameter RSB_INIT (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on stand-in) |
| sen_i | input | 1 | Serial enable, word framing |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data |
| band_o | output | 4 | Band-select outputs |
| freq_o | output | 15 | Divider ratio |
| cp_o | output | 1 | Pump current select, 1 = high |
| test_o | output | 3 | Test mode bits t2..t0 |
| rsa_o | output | 1 | Reference ratio bit A |
| rsb_o | output | 1 | Reference ratio bit B |
| os_o | output | 1 | Tuning output disable, 1 = off |

## Verification
The bit counter decides which of the registers gets loaded, so a counter that is off by one does not show up as a subtly wrong value. It shows up as a load that never happens, a load at the wrong edge, or a field shifted by one bit. The bench therefore checks band_o immediately after the 5th rising edge and freq_o immediately after the 20th, and it checks every output within two system clocks of enable falling. A corrupted shift register shows as a wrong field value at the first load that follows. Lost control state shows only after a later short word, so the bench runs short words after long ones.

// File: rtl/serial_tune_loader.sv
module serial_tune_loader #(
  parameter int BAND_W   = 4,
  parameter int FREQ_W   = 15,
  parameter int CNT_W    = 5,
  parameter bit RSB_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic [BAND_W-1:0] band_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              cp_o,
  output logic [2:0]        test_o,
  output logic              rsa_o,
  output logic              rsb_o,
  output logic              os_o
);
  localparam int CTRL_W = 8;
  localparam logic [CNT_W-1:0] BAND_AT = CNT_W'(BAND_W);
  localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(BAND_W + FREQ_W - 1);
  localparam logic [CNT_W-1:0] LEN_F   = CNT_W'(BAND_W + FREQ_W);
  localparam logic [CNT_W-1:0] LEN_X   = CNT_W'(BAND_W + FREQ_W + CTRL_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              sclk_q, sen_q;
  logic [CNT_W-1:0]  cnt;
  logic [FREQ_W-1:0] sr;

  wire rise = sen_i &  sclk_i & ~sclk_q;
  wire fall = sen_i & ~sclk_i &  sclk_q;
  wire done = sen_q & ~sen_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
      band_o <= '0;
      freq_o <= '0;
      cp_o   <= 1'b1;
      test_o <= 3'b001;
      rsa_o  <= 1'b0;
      rsb_o  <= RSB_INIT;
      os_o   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      sen_q  <= sen_i;
      if (!sen_i) cnt <= '0;
      else if (fall && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (fall) sr <= {sr[FREQ_W-2:0], sdat_i};
      if (rise && cnt == BAND_AT) band_o <= sr[BAND_W-1:0];
      if (rise && cnt == LEN_F) freq_o <= sr;
      if (done) begin
        if (cnt == LEN_S) begin
          freq_o <= {1'b0, sr[FREQ_W-2:0]};
          rsa_o  <= 1'b1;
        end else if (cnt == LEN_F) begin
          freq_o <= sr;
          rsa_o  <= 1'b0;
        end else if (cnt == LEN_X) begin
          cp_o   <= sr[6];
          test_o <= sr[5:3];
          rsa_o  <= sr[2];
          rsb_o  <= sr[1];
          os_o   <= sr[0];
        end
      end
    end
  end
endmodule

module serial_tune_loader_chk #(
  parameter int BAND_W = 4,
  parameter int FREQ_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sen_i,
  input logic              sclk_i,
  input logic [BAND_W-1:0] band_o,
  input logic [FREQ_W-1:0] freq_o,
  input logic              cp_o,
  input logic [2:0]        test_o,
  input logic              rsa_o,
  input logic              rsb_o,
  input logic              os_o
);
  logic sen_d, sclk_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sen_d  <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      sen_d  <= sen_i;
      sclk_d <= sclk_i;
    end
  end

  wire ev_rise = sen_i & sclk_i & ~sclk_d;
  wire ev_end  = sen_d & ~sen_i;

  AST_BAND_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_o) |-> $past(ev_rise)); // R3
  AST_FREQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_o) |-> $past(ev_rise || ev_end)); // R6
  AST_CTRL_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_end |=> $stable({cp_o, test_o, rsb_o, os_o})); // R7
  AST_RSA_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsa_o) |-> $past(ev_end)); // R2
  AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(freq_o) && $past(ev_end) && rsa_o) |-> !freq_o[FREQ_W-1]); // R4
endmodule

bind serial_tune_loader serial_tune_loader_chk #(.BAND_W(BAND_W), .FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sen_i(sen_i), .sclk_i(sclk_i),
  .band_o(band_o), .freq_o(freq_o), .cp_o(cp_o), .test_o(test_o),
  .rsa_o(rsa_o), .rsb_o(rsb_o), .os_o(os_o)
);

// File: tb/serial_tune_loader_bench.sv
module serial_tune_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic [3:0]  band;
  logic [14:0] freq;
  logic        cp, rsa, rsb, os;
  logic [2:0]  test;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  serial_tune_loader u_serial_tune_loader (
    .clk(clk), .rst_n(rst_n), .sen_i(sen), .sclk_i(sclk), .sdat_i(sdat),
    .band_o(band), .freq_o(freq), .cp_o(cp), .test_o(test),
    .rsa_o(rsa), .rsb_o(rsb), .os_o(os)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_ctrl(input string tag, input logic ecp, input logic [2:0] et,
                          input logic ersa, input logic ersb, input logic eos);
    chk({tag, " cp"},   32'(cp),   32'(ecp));
    chk({tag, " test"}, 32'(test), 32'(et));
    chk({tag, " rsa"},  32'(rsa),  32'(ersa));
    chk({tag, " rsb"},  32'(rsb),  32'(ersb));
    chk({tag, " os"},   32'(os),   32'(eos));
  endtask

  task automatic send_word(input logic [26:0] w, input int len);
    sen = 1'b1;
    tick(2);
    for (int i = len - 1; i >= 0; i--) begin
      sdat = w[i];
      sclk = 1'b1;
      tick(2);
      if (len - i == 5) chk("R3 band at 5th rise", 32'(band), 32'(w[len-1 -: 4]));
      if (len - i == 20) chk("R6 freq at 20th rise", 32'(freq), 32'(w[len-5 -: 15]));
      sclk = 1'b0;
      tick(2);
    end
    sen = 1'b0;
    tick(3);
  endtask

  task automatic t_reset;
    chk("R1 band", 32'(band), 0);
    chk("R1 freq", 32'(freq), 0);
    chk_ctrl("R1/R10 reset", 1'b1, 3'b001, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_idle_clock;
    sdat = 1'b1;
    for (int k = 0; k < 12; k++) begin
      sclk = ~sclk;
      tick(2);
    end
    sclk = 1'b0;
    tick(2);
    chk("R2 idle band", 32'(band), 0);
    chk("R2 idle freq", 32'(freq), 0);
    chk_ctrl("R2 idle", 1'b1, 3'b001, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_w18;
    send_word(27'({4'b1010, 14'h2A5B}), 18);
    chk("R4 freq", 32'(freq), 32'h2A5B);
    chk("R3 band", 32'(band), 32'hA);
    chk_ctrl("R4/R7 18-bit", 1'b1, 3'b001, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_w19;
    send_word(27'({4'b0101, 15'h6C3D}), 19);
    chk("R5 freq", 32'(freq), 32'h6C3D);
    chk_ctrl("R5/R7 19-bit", 1'b1, 3'b001, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_w27a;
    send_word({4'b1100, 15'h1234, 8'hA0}, 27);
    chk("R6 freq kept", 32'(freq), 32'h1234);
    chk("R3 band", 32'(band), 32'hC);
    chk_ctrl("R6 ctrl A0", 1'b0, 3'b100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_w18_hold;
    send_word(27'({4'b0011, 14'h0F0F}), 18);
    chk("R4 freq", 32'(freq), 32'h0F0F);
    chk_ctrl("R7 hold after 18", 1'b0, 3'b100, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_short;
    send_word(27'({4'b1111, 6'h3F}), 10);
    chk("R3 short band", 32'(band), 32'hF);
    chk("R8 short freq", 32'(freq), 32'h0F0F);
    chk_ctrl("R8 short", 1'b0, 3'b100, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_odd;
    send_word(27'({4'b0110, 15'h7001, 3'b101}), 22);
    chk("R9 odd freq", 32'(freq), 32'h7001);
    chk_ctrl("R9 odd", 1'b0, 3'b100, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_w27b;
    send_word({4'b1001, 15'h5555, 8'h4F}, 27);
    chk("R6 freq", 32'(freq), 32'h5555);
    chk_ctrl("R6 ctrl 4F", 1'b1, 3'b001, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_w19_hold;
    send_word(27'({4'b0000, 15'h4001}), 19);
    chk("R5 top bit", 32'(freq), 32'h4001);
    chk_ctrl("R7 hold after 19", 1'b1, 3'b001, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_idle_clock();
    t_w18();
    t_w19();
    t_w27a();
    t_w18_hold();
    t_short();
    t_odd();
    t_w27b();
    t_w19_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule